// File: doc/BRIEF.md
# Rotary Dial Combination Lock

This block is a clocked model of a locker's rotary dial lock. It receives a stream of dial positions, each qualified by a valid strobe. From that stream it works out which way the dial is turning, how often the dial has crossed the number it currently wants, and whether the dial has come to rest. It drives a clasp output that is either locked or unlocked.

The combination has three numbers, X, Y and Z, and each is set by a parameter. The sequence to open the lock is:

1. Turn right so that the dial passes X twice, then rest on X.
2. Turn left so that the dial passes Y once, then rest on Y.
3. Turn right and rest on Z.

The clasp then stays open until a relock pulse arrives. A debug view brings out the current step, the crossing count and the last turning direction.

The dial has 40 positions, numbered 0 to 39. Position 39 is followed by position 0. A crossing is counted on the move that lands on the target, so the move on which the dial finally arrives also counts. "Pass twice then rest" therefore needs three crossings. "Pass once" needs two crossings, and the last step needs one.

Top module: `dial_lock`

## Requirements
- R1: Synchronous active-high `rst` sets `unlocked`=0, `dbg_step`=0, `dbg_passes`=0 and `dbg_right`=0. The next accepted sample only records the reference position and counts as no move.
- R2: A move is an accepted sample whose position differs from the previous accepted position. Let f be (new − old) mod 40. If f is between 1 and 19 the move is to the right; if f is between 20 and 39 it is to the left. `dbg_right` shows the direction of the last move (1 = right). For example, 39→0 is a right move and 0→39 is a left move.
- R3: A move in the direction the current step wants increments `dbg_passes` if the target lies in the swept arc, which runs from after the old position up to and including the new one. The count saturates at 3. The step encoding is 0 = seek X (right), 1 = seek Y (left), 2 = seek Z (right), 3 = open.
- R4: A stop is declared on the fourth consecutive accepted sample that repeats the previous position. Further repeats declare nothing more until the dial moves again.
- R5: In step 0, a stop on X with at least 3 crossings moves the lock to step 1 and clears the count.
- R6: In step 1, a stop on Y with at least 2 crossings moves the lock to step 2 and clears the count.
- R7: In step 2, a stop on Z with at least 1 crossing moves the lock to step 3 and raises `unlocked`. This is the only way `unlocked` rises.
- R8: A move in the wrong direction for the current step returns the lock to step 0 with the count cleared.
- R9: A stop on any position other than the target, or a stop on the target with too few crossings, returns the lock to step 0 with the count cleared.
- R10: While open, `unlocked` stays 1 and every dial sample is ignored until `relock` is seen.
- R11: `relock` clears all tracking state exactly as `rst` does. It takes priority over a dial sample in the same cycle.
- R12: A valid sample with a position of 40 or above is ignored. Cycles with `pos_valid`=0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_valid | input | 1 | Qualifies `pos` this cycle |
| pos | input | 6 | Dial position, 0 to 39 |
| relock | input | 1 | Closes the clasp and clears all tracking |
| unlocked | output | 1 | 1 when the clasp is open |
| dbg_step | output | 2 | Current step (0 = X, 1 = Y, 2 = Z, 3 = open) |
| dbg_passes | output | 2 | Crossings of the current target |
| dbg_right | output | 1 | Direction of the last move, 1 = right |

## Verification
Two events can fall in the same cycle: the sample that completes the final stop on Z, and a relock pulse. The bench provokes this by walking a correct combination up to three repeats on Z. It then presents the fourth repeat together with `relock`, and requires the lock to stay closed and return to step 0. Every other cycle of the directed walks and of a long pseudo-random stream is compared against an arithmetic model of the dial that the bench keeps. That stream mixes invalid positions, wraps and large jumps.

// File: rtl/dial_lock.sv
module dial_lock #(
  parameter int N       = 40,
  parameter int PW      = 6,
  parameter int CODE_X  = 12,
  parameter int CODE_Y  = 30,
  parameter int CODE_Z  = 5,
  parameter int CROSS_X = 3,
  parameter int CROSS_Y = 2,
  parameter int CROSS_Z = 1,
  parameter int HOLD    = 4,
  localparam int CW     = $clog2(CROSS_X + 1),
  localparam int HW     = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pos_valid,
  input  logic [PW-1:0] pos,
  input  logic          relock,
  output logic          unlocked,
  output logic [1:0]    dbg_step,
  output logic [CW-1:0] dbg_passes,
  output logic          dbg_right
);

  logic [1:0]    step;
  logic [PW-1:0] prev;
  logic          have;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic          right;

  int   tgt, need, d, span, td;
  logic want_r, mv_r, crossed;
  logic moved, take, stop;

  function automatic int fdist(int a, int b);
    return (a >= b) ? a - b : a + N - b;
  endfunction

  always_comb begin
    case (step)
      2'd0:    begin tgt = CODE_X; need = CROSS_X; end
      2'd1:    begin tgt = CODE_Y; need = CROSS_Y; end
      default: begin tgt = CODE_Z; need = CROSS_Z; end
    endcase
    want_r  = step != 2'd1;
    d       = fdist(int'(pos), int'(prev));
    mv_r    = d < N / 2;
    span    = mv_r ? d : N - d;
    td      = mv_r ? fdist(tgt, int'(prev)) : fdist(int'(prev), tgt);
    crossed = (td >= 1) && (td <= span);
  end

  assign moved = pos != prev;
  assign take  = pos_valid && (int'(pos) < N) && (step != 2'd3);
  assign stop  = have && !moved && (hold == HW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst || relock) begin
      step  <= 2'd0;
      prev  <= '0;
      have  <= 1'b0;
      cnt   <= '0;
      hold  <= '0;
      right <= 1'b0;
    end else if (take) begin
      prev <= pos;
      have <= 1'b1;
      if (!have) begin
        hold <= '0;
      end else if (moved) begin
        hold  <= '0;
        right <= mv_r;
        if (mv_r != want_r) begin
          step <= 2'd0;
          cnt  <= '0;
        end else if (crossed && cnt != CW'(CROSS_X)) begin
          cnt <= cnt + 1'b1;
        end
      end else if (hold != HW'(HOLD)) begin
        hold <= hold + 1'b1;
        if (stop) begin
          cnt  <= '0;
          step <= (int'(pos) == tgt && int'(cnt) >= need) ? step + 2'd1 : 2'd0;
        end
      end
    end
  end

  assign unlocked   = step == 2'd3;
  assign dbg_step   = step;
  assign dbg_passes = cnt;
  assign dbg_right  = right;

endmodule

// File: rtl/dial_lock_chk.sv
module dial_lock_chk #(
  parameter int N  = 40,
  parameter int PW = 6,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pos_valid,
  input logic [PW-1:0] pos,
  input logic          relock,
  input logic          unlocked,
  input logic [1:0]    dbg_step,
  input logic [CW-1:0] dbg_passes,
  input logic          dbg_right
);

  p_reset_locked_r1: assert property (@(posedge clk)
    rst |=> !unlocked && dbg_step == 2'd0 && dbg_passes == '0 && !dbg_right);

  p_relock_clears_r11: assert property (@(posedge clk) disable iff (rst)
    relock |=> !unlocked && dbg_step == 2'd0 && dbg_passes == '0);

  p_open_holds_r10: assert property (@(posedge clk) disable iff (rst)
    unlocked && !relock |=> unlocked && $stable(dbg_right) && $stable(dbg_passes));

  p_open_from_z_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(dbg_step) == 2'd2);

  p_bad_pos_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    pos_valid && pos >= PW'(N) && !relock |=>
      $stable(dbg_step) && $stable(dbg_passes) && $stable(dbg_right));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    !pos_valid && !relock |=> $stable(dbg_step) && $stable(dbg_passes));

  p_step_order_r5: assert property (@(posedge clk) disable iff (rst)
    !relock |=> dbg_step == 2'd0 || dbg_step == $past(dbg_step) ||
                dbg_step == $past(dbg_step) + 2'd1);

  p_cross_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    !relock |=> dbg_passes == '0 || dbg_passes == $past(dbg_passes) ||
                dbg_passes == $past(dbg_passes) + 1'b1);

endmodule

bind dial_lock dial_lock_chk #(.N(N), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .pos_valid(pos_valid), .pos(pos), .relock(relock),
  .unlocked(unlocked), .dbg_step(dbg_step), .dbg_passes(dbg_passes),
  .dbg_right(dbg_right)
);

// File: tb/dial_lock_tb.sv
`timescale 1ns/1ps
module dial_lock_tb;
  logic clk = 0, rst = 1, pos_valid = 0, relock = 0;
  logic [5:0] pos = '0;
  logic unlocked, dbg_right;
  logic [1:0] dbg_step, dbg_passes;

  int nvec = 0, nbad = 0, cur = 0;
  int m_step, m_prev, m_have, m_cnt, m_hold, m_right;

  always #5 clk = ~clk;

  dial_lock u_dut (.clk(clk), .rst(rst), .pos_valid(pos_valid), .pos(pos),
    .relock(relock), .unlocked(unlocked), .dbg_step(dbg_step),
    .dbg_passes(dbg_passes), .dbg_right(dbg_right));

  task automatic mclear();
    m_step = 0; m_prev = 0; m_have = 0; m_cnt = 0; m_hold = 0; m_right = 0;
  endtask

  task automatic model(bit v, int p, bit rl);
    int tgt, need, fwd, span, td;
    bit r, wr;
    if (rl) begin mclear(); return; end
    if (!v || p >= 40 || m_step == 3) return;
    if (!m_have) begin m_have = 1; m_prev = p; m_hold = 0; return; end
    tgt  = (m_step == 0) ? 12 : (m_step == 1) ? 30 : 5;
    need = (m_step == 0) ? 3 : (m_step == 1) ? 2 : 1;
    wr   = m_step != 1;
    if (p != m_prev) begin
      fwd = (p - m_prev + 40) % 40;
      r = fwd < 20; m_right = r; m_hold = 0;
      if (r != wr) begin m_step = 0; m_cnt = 0; end
      else begin
        span = r ? fwd : 40 - fwd;
        td = r ? (tgt - m_prev + 40) % 40 : (m_prev - tgt + 40) % 40;
        if (td >= 1 && td <= span && m_cnt < 3) m_cnt++;
      end
    end else if (m_hold < 4) begin
      m_hold++;
      if (m_hold == 4) begin
        m_step = (p == tgt && m_cnt >= need) ? m_step + 1 : 0;
        m_cnt = 0;
      end
    end
    m_prev = p;
  endtask

  task automatic check(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    check({tag, " step"}, dbg_step, m_step);
    check({tag, " passes"}, dbg_passes, m_cnt);
    check({tag, " dir"}, dbg_right, m_right);
    check({tag, " clasp"}, unlocked, m_step == 3);
  endtask

  task automatic apply(bit v, int p, bit rl, string tag);
    @(negedge clk);
    pos_valid = v; pos = 6'(p); relock = rl;
    @(posedge clk); #1;
    model(v, p, rl);
    pos_valid = 0; relock = 0;
    cmp(tag);
  endtask

  task automatic go(bit right, int n, string tag);
    for (int i = 0; i < n; i++) begin
      cur = right ? (cur + 1) % 40 : (cur + 39) % 40;
      apply(1, cur, 0, tag);
    end
  endtask

  task automatic rest(int n, string tag);
    for (int i = 0; i < n; i++) apply(1, cur, 0, tag);
  endtask

  task automatic restart(string tag);
    apply(0, 0, 1, tag);
    cur = 0;
    apply(1, 0, 0, tag);
  endtask

  task automatic open_seq();
    restart("R1");
    go(1, 12, "R3"); go(1, 40, "R3"); go(1, 40, "R3");
    rest(4, "R5"); check("R5 step1", dbg_step, 1);
    go(0, 22, "R2"); go(0, 40, "R3");
    rest(4, "R6"); check("R6 step2", dbg_step, 2);
    go(1, 15, "R2");
    rest(4, "R7");
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    mclear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    cmp("R1 reset");

    open_seq();
    check("R7 open", unlocked, 1);
    apply(1, 20, 0, "R10"); apply(1, 20, 0, "R10"); apply(1, 45, 0, "R10");
    check("R10 still open", unlocked, 1);
    apply(0, 0, 1, "R11"); check("R11 relocked", unlocked, 0);

    restart("R3");
    go(1, 12, "R3"); go(1, 40, "R3");
    rest(4, "R9"); check("R9 few crossings", dbg_step, 0);

    restart("R8");
    go(1, 12, "R3"); go(1, 80, "R3"); rest(4, "R5");
    go(1, 3, "R8"); check("R8 wrong dir", dbg_step, 0);

    restart("R9");
    go(1, 12, "R3"); go(1, 80, "R3"); go(1, 1, "R3");
    rest(4, "R9"); check("R9 wrong number", dbg_step, 0);

    restart("R2");
    cur = 39; apply(1, 39, 0, "R2"); apply(1, 0, 0, "R2");
    check("R2 wrap right", dbg_right, 1);
    apply(1, 39, 0, "R2"); check("R2 wrap left", dbg_right, 0);

    restart("R3");
    for (int k = 0; k < 18; k++) begin
      cur = (cur + 7) % 40; apply(1, cur, 0, "R3 jump");
    end
    apply(1, 52, 0, "R12"); apply(0, 3, 0, "R12");
    rest(3, "R4"); rest(5, "R4");

    open_seq();
    check("R7 second open", unlocked, 1);
    apply(0, 0, 1, "R11");
    restart("R11");
    go(1, 12, "R3"); go(1, 80, "R3"); rest(4, "R5");
    go(0, 22, "R6"); go(0, 40, "R6"); rest(4, "R6");
    go(1, 15, "R7"); rest(3, "R4");
    apply(1, cur, 1, "R11 coincident");
    check("R11 relock wins", unlocked, 0);
    check("R11 step cleared", dbg_step, 0);

    for (int k = 0; k < 6000; k++) begin
      bit v, rl;
      int p;
      v  = ($urandom % 10) != 0;
      rl = ($urandom % 100) == 0;
      p  = ($urandom % 3 == 0) ? cur : $urandom % 44;
      if (p < 40) cur = p;
      apply(v, p, rl, "R2 sweep");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule